// File: doc/BRIEF.md
# Multi-Source XOR Engine with Zero Check

This block executes one memory-to-memory operation per start pulse. The operation is described by a 32-bit control word, three extension control words, up to 32 source base addresses, a destination base address and a byte count. For each 32-bit word position it reads the enabled sources one at a time, folds them together with XOR and writes the result to the destination. It has two other modes. The block-fill mode writes a 32-bit constant across the destination. The parity-check mode writes nothing and records whether any result word was non-zero. When it finishes, it returns the control word with its completion and check-result bits updated, pulses a done strobe, and raises an interrupt request if the descriptor asks for one.

Each source has its own 3-bit command field. Sources 1 to 8 have their fields in the main control word, and sources 9 to 32 have theirs in the extension words. A 2-bit source-range field in the control word decides how many of these fields are read at all. The memory port has a fixed latency of one cycle: read data is valid in the cycle after the read request.

The controller is a state machine. IDLE waits for a start pulse. On start it latches the descriptor and moves to PICK. PICK begins one word position. It goes to DONE if the words are used up or the operation is a null operation. Otherwise it goes to WRITE in fill mode, to READ if any source is enabled, and to WRITE (with a zero result) if none is. READ issues a source read and moves to ACC. ACC folds in the returned data. From ACC the machine goes to READ if another enabled source remains, then to WRITE if destination write is on, and otherwise to ADV. WRITE stores the word and moves to ADV. ADV steps the offset and the word count and returns to PICK. DONE publishes the status for one cycle and returns to IDLE.

Top module: `xz_engine`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `irq` and `mem_req` are all 0.
- R2: The source-range field (control bits 26:25) limits which sources are considered, whatever their command fields hold. Value 0 allows sources 1-4. Value 1 allows 1-8. Value 2 adds sources 9-16, whose fields are in extension word 0. Value 3 adds sources 17-32, whose fields are in extension words 1 and 2. Source k of 1-8 has its field at main-word bits 3(k-1)+3:3(k-1)+1. Within each extension word the eight fields start at bit 1, also 3 bits apart.
- R3: Command code 7 or 1 on source 1 takes that source into the result. Code 1 on any other source takes it in. Every other code, including 0, leaves the source out.
- R4: For each word position, the enabled sources are read in ascending source order. Each read is at source base + 4·w, and each write is at destination base + 4·w, where w is the word index.
- R5: When destination write enable (bit 31) is set, the XOR of all enabled sources for word w is written to destination word w.
- R6: Code 2 on source 1 selects block fill. Source 1's address value is written to every destination word, and no source is read. With destination write clear, a fill makes no memory access at all.
- R7: With destination write clear, nothing is written. When zero-check enable (bit 30) is set, status bit 29 reports 1 if any XOR result word was non-zero and 0 otherwise, whatever value that bit had on input.
- R8: The byte count is clipped to 1024 bytes when zero-check enable is set, and to 16 MiB otherwise. Only clipped/4 word positions are processed.
- R9: On completion, `status_word` equals the control word with bit 28 set and bit 29 set to the zero-check result, and `done` is high for exactly one cycle. `irq` pulses together with `done` exactly when control bit 0 is set.
- R10: An operation with no enabled source and destination write clear, or with a byte count of 0, makes no memory access and signals done two cycles after the start edge.
- R11: A start pulse that arrives while the block is busy is ignored. The operation in progress continues unchanged, and no second operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; descriptor inputs are latched with it |
| desc_ctrl | input | 32 | Main control word |
| desc_ext | input | 96 | Three extension control words, word 0 in the low 32 bits |
| src_addr | input | MAX_SRC·32 | Source base addresses, source 1 in the low 32 bits |
| dst_addr | input | 32 | Destination base address |
| byte_cnt | input | CNT_W | Transfer length in bytes, a multiple of 4 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Interrupt request, pulsed with done |
| status_word | output | 32 | Control word returned with completion and check bits |

## Verification
The hardest case to reach from the ports is a parity check whose byte count exceeds the clip limit. In that case the only words that differ between the sources lie beyond the 1024-byte limit. A correct engine reports a zero result and reads exactly 256 word positions. An engine that ignores the clip reports non-zero and reads more. The bench sets up two source regions that are identical for 256 words and differ in the four words after them. It then runs a 1040-byte check and compares every read address against a scoreboard as well as the returned status bit. A start pulse injected in the middle of an operation, with an inverted control word, shows whether the latched descriptor can be disturbed.

// File: rtl/xz_pkg.sv
package xz_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_READ,
        ST_ACC,
        ST_WRITE,
        ST_ADV,
        ST_DONE
    } xz_state_t;

    localparam int CTL_W       = 32;
    localparam int FIELD_W     = 3;
    localparam int FIELDS_WORD = 8;
    localparam int FIELD_LSB   = 1;

    localparam int BIT_IRQ_EN  = 0;
    localparam int RANGE_LSB   = 25;
    localparam int BIT_DONE    = 28;
    localparam int BIT_ZERR    = 29;
    localparam int BIT_ZEN     = 30;
    localparam int BIT_DWE     = 31;

    localparam logic [2:0] CMD_XOR   = 3'd1;
    localparam logic [2:0] CMD_BFILL = 3'd2;
    localparam logic [2:0] CMD_LOAD  = 3'd7;

endpackage

// File: rtl/xz_src_decode.sv
module xz_src_decode
    import xz_pkg::*;
#(
    parameter int MAX_SRC = 32,
    parameter int N_EXT   = 3
) (
    input  logic [CTL_W-1:0]            main_w,
    input  logic [N_EXT-1:0][CTL_W-1:0] ext_w,
    output logic [MAX_SRC-1:0]          src_en,
    output logic                        fill
);
    logic [1:0] range_sel;
    assign range_sel = main_w[RANGE_LSB +: 2];
    assign fill      = (main_w[FIELD_LSB +: FIELD_W] == CMD_BFILL);

    logic unused_bits;
    assign unused_bits = ^{main_w[BIT_IRQ_EN], main_w[CTL_W-1:RANGE_LSB+2], ext_w};

    for (genvar i = 0; i < MAX_SRC; i++) begin : g_src
        localparam int WSEL = i / FIELDS_WORD;
        localparam int FPOS = FIELD_LSB + FIELD_W * (i % FIELDS_WORD);
        localparam int TIER = (i < 4) ? 0 : (i < 8) ? 1 : (i < 16) ? 2 : 3;
        logic [FIELD_W-1:0] code;
        logic               tier_ok;
        if (WSEL == 0) begin : g_main
            assign code = main_w[FPOS +: FIELD_W];
        end else begin : g_ext
            assign code = ext_w[WSEL-1][FPOS +: FIELD_W];
        end
        assign tier_ok = (range_sel >= 2'(TIER));
        if (i == 0) begin : g_first
            assign src_en[i] = tier_ok && ((code == CMD_LOAD) || (code == CMD_XOR));
        end else begin : g_other
            assign src_en[i] = tier_ok && (code == CMD_XOR);
        end
    end
endmodule

// File: rtl/xz_lowest.sv
module xz_lowest #(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int j = N - 1; j >= 0; j--) begin
            if (req[j]) begin
                found = 1'b1;
                idx   = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/xz_word_count.sv
module xz_word_count #(
    parameter int CNT_W         = 32,
    parameter int XOR_MAX_BYTES = 16777216,
    parameter int ZC_MAX_BYTES  = 1024,
    parameter int BYTE_SHIFT    = 2
) (
    input  logic [CNT_W-1:0] bytes,
    input  logic             zero_check,
    output logic [CNT_W-1:0] words
);
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] eff;

    assign limit = zero_check ? CNT_W'(ZC_MAX_BYTES) : CNT_W'(XOR_MAX_BYTES);
    assign eff   = (bytes > limit) ? limit : bytes;
    assign words = eff >> BYTE_SHIFT;
endmodule

// File: rtl/xz_engine.sv
module xz_engine
    import xz_pkg::*;
#(
    parameter int MAX_SRC       = 32,
    parameter int WORD_W        = 32,
    parameter int CNT_W         = 32,
    parameter int XOR_MAX_BYTES = 16777216,
    parameter int ZC_MAX_BYTES  = 1024
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [CTL_W-1:0]          desc_ctrl,
    input  logic [3*CTL_W-1:0]        desc_ext,
    input  logic [MAX_SRC*WORD_W-1:0] src_addr,
    input  logic [WORD_W-1:0]         dst_addr,
    input  logic [CNT_W-1:0]          byte_cnt,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [WORD_W-1:0]         mem_addr,
    output logic [WORD_W-1:0]         mem_wdata,
    input  logic [WORD_W-1:0]         mem_rdata,
    output logic                      busy,
    output logic                      done,
    output logic                      irq,
    output logic [CTL_W-1:0]          status_word
);
    localparam int IDX_W  = (MAX_SRC > 1) ? $clog2(MAX_SRC) : 1;
    localparam int N_EXT  = 3;
    localparam int STEP   = WORD_W / 8;
    localparam int SHIFT  = $clog2(STEP);

    xz_state_t state, nxt;

    logic [CTL_W-1:0]            ctrl_q;
    logic [N_EXT-1:0][CTL_W-1:0] ext_q;
    logic [WORD_W-1:0]           src_q [MAX_SRC];
    logic [WORD_W-1:0]           dst_q;
    logic [CNT_W-1:0]            words_left;
    logic [WORD_W-1:0]           offs;
    logic [WORD_W-1:0]           acc;
    logic [IDX_W-1:0]            cur;
    logic                        zerr;
    logic [CTL_W-1:0]            status_q;

    logic [MAX_SRC-1:0] src_en;
    logic               fill;
    logic [CNT_W-1:0]   words_in;
    logic [MAX_SRC-1:0] above_cur;
    logic [MAX_SRC-1:0] search_vec;
    logic               pick_found;
    logic [IDX_W-1:0]   pick_idx;
    logic               any_en;
    logic               dwe;
    logic               zen;
    logic               finish_now;
    logic [WORD_W-1:0]  acc_nx;

    xz_src_decode #(.MAX_SRC(MAX_SRC), .N_EXT(N_EXT)) u_decode (
        .main_w (ctrl_q),
        .ext_w  (ext_q),
        .src_en (src_en),
        .fill   (fill)
    );

    xz_word_count #(
        .CNT_W(CNT_W), .XOR_MAX_BYTES(XOR_MAX_BYTES),
        .ZC_MAX_BYTES(ZC_MAX_BYTES), .BYTE_SHIFT(SHIFT)
    ) u_count (
        .bytes      (byte_cnt),
        .zero_check (desc_ctrl[BIT_ZEN]),
        .words      (words_in)
    );

    always_comb begin
        for (int j = 0; j < MAX_SRC; j++) begin
            above_cur[j] = (j > int'(cur));
        end
        search_vec = (state == ST_ACC) ? (src_en & above_cur) : src_en;
    end

    xz_lowest #(.N(MAX_SRC), .IDX_W(IDX_W)) u_lowest (
        .req   (search_vec),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign any_en     = |src_en;
    assign dwe        = ctrl_q[BIT_DWE];
    assign zen        = ctrl_q[BIT_ZEN];
    assign finish_now = (words_left == '0) || (!dwe && (fill || !any_en));
    assign acc_nx     = acc ^ mem_rdata;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_PICK;
            ST_PICK: begin
                if (finish_now)  nxt = ST_DONE;
                else if (fill)   nxt = ST_WRITE;
                else if (any_en) nxt = ST_READ;
                else             nxt = ST_WRITE;
            end
            ST_READ:  nxt = ST_ACC;
            ST_ACC: begin
                if (pick_found) nxt = ST_READ;
                else if (dwe)   nxt = ST_WRITE;
                else            nxt = ST_ADV;
            end
            ST_WRITE: nxt = ST_ADV;
            ST_ADV:   nxt = ST_PICK;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            ext_q      <= '0;
            dst_q      <= '0;
            words_left <= '0;
            offs       <= '0;
            acc        <= '0;
            cur        <= '0;
            zerr       <= 1'b0;
            status_q   <= '0;
            for (int i = 0; i < MAX_SRC; i++) src_q[i] <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        ctrl_q     <= desc_ctrl;
                        ext_q      <= desc_ext;
                        dst_q      <= dst_addr;
                        words_left <= words_in;
                        offs       <= '0;
                        zerr       <= 1'b0;
                        for (int i = 0; i < MAX_SRC; i++)
                            src_q[i] <= src_addr[i*WORD_W +: WORD_W];
                    end
                end
                ST_PICK: begin
                    acc <= fill ? src_q[0] : '0;
                    cur <= pick_idx;
                    if (finish_now)
                        status_q <= {ctrl_q[BIT_DWE], ctrl_q[BIT_ZEN], zerr, 1'b1,
                                     ctrl_q[BIT_DONE-1:0]};
                end
                ST_ACC: begin
                    acc <= acc_nx;
                    cur <= pick_idx;
                    if (!pick_found && zen && (acc_nx != '0)) zerr <= 1'b1;
                end
                ST_ADV: begin
                    offs       <= offs + WORD_W'(STEP);
                    words_left <= words_left - CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = (state == ST_READ) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_addr  = (state == ST_READ) ? (src_q[cur] + offs) : (dst_q + offs);
        mem_wdata = acc;
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        irq       = (state == ST_DONE) && ctrl_q[BIT_IRQ_EN];
    end

    assign status_word = status_q;

    // R1
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    // R9
    irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dwe) |-> !(mem_req && mem_we));
    // R6
    fill_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fill) |-> !(mem_req && !mem_we));
    // R11
    hold_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(ctrl_q));
endmodule

// File: tb/xz_engine_tb.sv
module xz_engine_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [31:0]  d_ctrl = '0;
    logic [95:0]  d_ext = '0;
    logic [1023:0] src_flat;
    logic [31:0]  d_dst = '0;
    logic [31:0]  d_bytes = '0;
    logic         mem_req, mem_we, busy, done, irq;
    logic [31:0]  mem_addr, mem_wdata, status_word;
    logic [31:0]  mem_rdata = '0;

    logic [31:0]  mem [0:4095];
    logic [31:0]  b_src [32];
    logic [63:0]  q_rd [$];
    logic [63:0]  q_wr [$];
    string        tag = "R1";
    int           n_cmp = 0;
    int           n_bad = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 32; i++) src_flat[i*32 +: 32] = b_src[i];
    end

    xz_engine u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .desc_ctrl(d_ctrl),
        .desc_ext(d_ext), .src_addr(src_flat), .dst_addr(d_dst),
        .byte_cnt(d_bytes), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .irq(irq), .status_word(status_word)
    );

    // memory responder: one-cycle read latency
    always @(posedge clk) begin
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[13:2]];
        if (mem_req && mem_we)  mem[mem_addr[13:2]] <= mem_wdata;
    end

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // monitor: compare every access with the scoreboard
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (mem_we) begin
                if (q_wr.size() == 0) check({tag, " R4 unexpected write"}, {mem_addr, mem_wdata}, 64'h0);
                else check({tag, " R4/R5 write"}, {mem_addr, mem_wdata}, q_wr.pop_front());
            end else begin
                if (q_rd.size() == 0) check({tag, " R4 unexpected read"}, {32'h0, mem_addr}, 64'h0);
                else check({tag, " R4 read"}, {32'h0, mem_addr}, q_rd.pop_front());
            end
        end
    end

    function automatic logic [31:0] fld(input int i, input int c);
        return 32'(c) << (1 + 3 * i);
    endfunction

    function automatic logic [31:0] pat(input int i);
        return (32'(i) * 32'h9E3779B1) ^ 32'h0000_5A5A;
    endfunction

    task automatic init_srcs();
        for (int s = 0; s < 32; s++) b_src[s] = 32'h400 + 32'(s) * 32'h80;
    endtask

    // driver: compute expected accesses from the requirements, then run
    task automatic run_desc(input string t, input logic [31:0] ctrl, input logic [95:0] ext,
                            input logic [31:0] bytes, input int poke_at, output int cyc);
        logic [2:0]  code;
        logic [1:0]  rng;
        logic        en [32];
        logic        fill, dwe, zen, zerr;
        logic [31:0] eff, acc;
        int          words, tier;
        tag  = t;
        rng  = ctrl[26:25];
        fill = (ctrl[3:1] == 3'd2);
        dwe  = ctrl[31];
        zen  = ctrl[30];
        zerr = 1'b0;
        for (int s = 0; s < 32; s++) begin
            code = (s < 8) ? ctrl[1 + 3*s +: 3] : ext[(s/8 - 1)*32 + 1 + 3*(s%8) +: 3];
            tier = (s < 4) ? 0 : (s < 8) ? 1 : (s < 16) ? 2 : 3;
            en[s] = (int'(rng) >= tier) && ((code == 3'd1) || (s == 0 && code == 3'd7));
        end
        eff   = zen ? ((bytes > 1024) ? 1024 : bytes) : ((bytes > 32'h100_0000) ? 32'h100_0000 : bytes);
        words = int'(eff / 4);
        for (int w = 0; w < words; w++) begin
            if (fill) begin
                if (dwe) q_wr.push_back({d_dst + 32'(4*w), b_src[0]});
            end else begin
                acc = '0;
                for (int s = 0; s < 32; s++) begin
                    if (en[s]) begin
                        q_rd.push_back({32'h0, b_src[s] + 32'(4*w)});
                        acc ^= mem[(b_src[s] + 32'(4*w)) >> 2];
                    end
                end
                if (zen && acc != 0) zerr = 1'b1;
                if (dwe) q_wr.push_back({d_dst + 32'(4*w), acc});
            end
        end
        @(negedge clk);
        d_ctrl = ctrl; d_ext = ext; d_bytes = bytes; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (cyc == poke_at) begin
                d_ctrl = ~ctrl; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        if (!done) check({t, " timeout"}, 64'h0, 64'h1);
        // R9 status word and irq
        check({t, " R9 status"}, {32'h0, status_word}, {32'h0, ctrl[31:30], zerr, 1'b1, ctrl[27:0]});
        check({t, " R9 irq"}, {63'h0, irq}, {63'h0, ctrl[0]});
        @(negedge clk);
        check({t, " R9 done pulse"}, {62'h0, done, busy}, 64'h0);
        check({t, " scoreboard empty"}, 64'(q_rd.size() + q_wr.size()), 64'h0);
        q_rd.delete(); q_wr.delete();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        logic [95:0] ext;
        for (int i = 0; i < 4096; i++) mem[i] = pat(i);
        for (int i = 0; i < 256; i++) mem[32'hE00 + i] = mem[32'hC00 + i];
        for (int i = 256; i < 260; i++) mem[32'hE00 + i] = ~mem[32'hC00 + i];
        init_srcs();
        d_dst = 32'h2000;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {60'h0, busy, done, irq, mem_req}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {60'h0, busy, done, irq, mem_req}, 64'h0);

        // R3 R5: two-source XOR, range 0
        run_desc("R5", 32'h8000_0000 | fld(0,7) | fld(1,1), '0, 16, 0, cyc);
        // R2 R3: source 6 outside range 0; codes 0 and 5 excluded; irq on
        run_desc("R3", 32'h8000_0001 | fld(0,7) | fld(1,1) | fld(2,0) | fld(3,5) | fld(5,1), '0, 16, 0, cyc);
        // R2: all 32 sources, range 3
        ext = '0;
        for (int k = 0; k < 24; k++) ext[(k/8)*32 + 1 + 3*(k%8) +: 3] = 3'd1;
        begin
            logic [31:0] c;
            c = 32'h8000_0001 | (32'd3 << 25) | fld(0,7);
            for (int k = 1; k < 8; k++) c |= fld(k,1);
            run_desc("R2 all32", c, ext, 8, 0, cyc);
        end
        // R2: range 2 uses extension word 0, ignores extension word 1
        ext = '0;
        ext[1 +: 3] = 3'd1; ext[10 +: 3] = 3'd1; ext[22 +: 3] = 3'd1; ext[32 + 1 +: 3] = 3'd1;
        run_desc("R2 range2", 32'h8000_0000 | (32'd2 << 25) | fld(0,7) | fld(4,1), ext, 12, 0, cyc);
        // R6: block fill writes the constant, no reads
        b_src[0] = 32'hA5A5_1234;
        run_desc("R6 fill", 32'h8000_0000 | fld(0,2) | fld(1,1), '0, 20, 0, cyc);
        run_desc("R6 fill nowrite", fld(0,2) | fld(1,1), '0, 20, 0, cyc);
        init_srcs();
        // R7: equal sources, input bit 29 preset, expect zero result
        b_src[0] = 32'h3000; b_src[1] = 32'h3800;
        run_desc("R7 zero", 32'h6000_0000 | fld(0,7) | fld(1,1), '0, 64, 0, cyc);
        // R8: differences lie beyond the 1024-byte clip
        run_desc("R8 clip", 32'h4000_0000 | fld(0,7) | fld(1,1), '0, 1040, 0, cyc);
        init_srcs();
        // R7: differing sources give a non-zero flag, no writes
        run_desc("R7 nonzero", 32'h4000_0001 | fld(0,7) | fld(1,1), '0, 32, 0, cyc);
        // R10: null operation and zero length
        run_desc("R10 null", 32'h4000_0000, '0, 64, 0, cyc);
        check("R10 null latency", 64'(cyc), 64'd1);
        run_desc("R10 zero len", 32'h8000_0000 | fld(0,7) | fld(1,1), '0, 0, 0, cyc);
        check("R10 zero len latency", 64'(cyc), 64'd1);
        // R11: start during busy is ignored
        run_desc("R11 poke", 32'h8000_0000 | fld(0,7) | fld(1,1) | fld(2,1), '0, 16, 5, cyc);
        repeat (4) @(negedge clk);
        check("R11 stays idle", {63'h0, busy}, 64'h0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule